// File: doc/BRIEF.md
# DMA Byte-Count Tracker

This block holds the remaining byte count for one DMA channel. Software loads a count while the channel is stopped, picks an operand size and then raises a start request. The block first checks that the count suits the operand size. If the check passes, it takes one operand off the count for each transfer the bus side reports as good. When the count reaches zero it raises a sticky completion flag. In external request mode it also sends a one-cycle done pulse to the requesting device. A bad count or size sets a sticky configuration-fault flag and drops the start bit without moving any data. A bus error stops the channel and leaves the count at the value the next access would have used.

The control is a three-state machine:
- `ST_IDLE`: stopped; the count may be written here.
- `ST_CHECK`: one cycle of validation.
- `ST_RUN`: counting transfers.

The transitions are:
- `IDLE->CHECK`: taken on a start request.
- `CHECK->IDLE`: taken on a fault; sets the fault flag.
- `CHECK->RUN`: taken when validation passes.
- `RUN->IDLE`: taken on the last good transfer (sets the done flag) or on a bus error.
- `RUN->RUN`: taken on other transfers or idle cycles.

Address generation and bus timing are handled outside this block.

Top module: `dma_byte_counter`

## Requirements
- R1: In `ST_RUN`, each `xfer_ok` without `bus_err` lowers `count` by the step for the size latched at start. The step is 1 for code 00 (byte), 2 for code 01 (word) and 4 for code 10 (long word). The new value is visible the cycle after the strobe.
- R2: When a good transfer brings `count` to zero, `done` becomes 1 and `busy` returns to 0 in the same following cycle.
- R3: `done_pulse` is high for exactly one cycle, together with the setting of `done`, only if `ext_mode` is 1 in the cycle of the last transfer. It never goes high when `ext_mode` is 0.
- R4: Word size (01) with an odd count sets `conf`, returns to idle and leaves `count` unchanged.
- R5: Long-word size (10) with a count that is not a multiple of 4 sets `conf`, returns to idle and leaves `count` unchanged.
- R6: A start request while the count is zero sets `conf`, and `busy` falls after the check cycle.
- R7: Size code 11 is reserved and fails validation with `conf` set, whatever the count.
- R8: `bus_err` in `ST_RUN` stops the channel (`busy` falls next cycle) and leaves `count` unchanged, even if `xfer_ok` is high in the same cycle. `done` is not set.
- R9: `cnt_wr` loads `cnt_wdata` into `count` only while `busy` is 0. While busy, writes are ignored.
- R10: `done` and `conf` stay set until their clear strobe (`clr_done`, `clr_conf`). If a set and a clear of the same flag fall in one cycle, the set wins.
- R11: After reset, `count`, `done`, `conf`, `busy` and `done_pulse` are all 0.
- R12: `busy` rises the cycle after a start request is accepted in idle. The check outcome (`conf` set, or counting enabled) takes effect one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Count write strobe (ignored while busy) |
| cnt_wdata | input | 32 | Count value to load |
| size_code | input | 2 | Operand size: 00 byte, 01 word, 10 long, 11 reserved |
| start_set | input | 1 | Start request strobe |
| ext_mode | input | 1 | External request mode select |
| xfer_ok | input | 1 | One operand transferred successfully |
| bus_err | input | 1 | Bus error ended the current transfer |
| clr_done | input | 1 | Write-one-to-clear for `done` |
| clr_conf | input | 1 | Write-one-to-clear for `conf` |
| count | output | 32 | Count for the next access |
| done | output | 1 | Sticky completion flag |
| conf | output | 1 | Sticky configuration-fault flag |
| busy | output | 1 | Start bit; cleared by the block on completion, fault or error |
| done_pulse | output | 1 | One-cycle done line for external request mode |

## Verification
A wrong state shows up at the ports at the latest one cycle after the stimulus that exposes it. A wrong step size changes `count` on the first good transfer. A missed check-state path shows as `busy` staying high with `conf` still low two cycles after the start request. A wrong priority between error and transfer shows as `count` moving on the error cycle. The bench runs a behavioural model in step with the design and compares every output on every clock, so a divergence is reported in the cycle it appears.

// File: rtl/btc_pkg.sv
package btc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_CHECK = 2'b01,
        ST_RUN   = 2'b10
    } btc_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } opsize_e;

    localparam int STEP_W = 3;

    function automatic logic [STEP_W-1:0] step_of(input opsize_e sz);
        unique case (sz)
            SZ_BYTE: step_of = 3'd1;
            SZ_WORD: step_of = 3'd2;
            SZ_LONG: step_of = 3'd4;
            default: step_of = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/btc_size_check.sv
module btc_size_check
    import btc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  opsize_e            size,
    input  logic [CNT_W-1:0]   count,
    output logic [STEP_W-1:0]  step,
    output logic               fault
);

    logic is_zero;
    logic bad_size;
    logic misaligned;

    assign is_zero = (count == '0);
    assign step    = step_of(size);

    always_comb begin
        bad_size   = 1'b0;
        misaligned = 1'b0;
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_WORD: misaligned = count[0];
            SZ_LONG: misaligned = |count[1:0];
            SZ_RSVD: bad_size   = 1'b1;
        endcase
    end

    assign fault = is_zero | bad_size | misaligned;

endmodule

// File: rtl/btc_count_reg.sv
module btc_count_reg
    import btc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               dec_en,
    input  logic [STEP_W-1:0]  step,
    output logic [CNT_W-1:0]   count,
    output logic               at_last
);

    localparam int PAD_W = CNT_W - STEP_W;

    logic [CNT_W-1:0] step_ext;

    assign step_ext = {{PAD_W{1'b0}}, step};
    assign at_last  = (count == step_ext);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (dec_en) begin
            count <= count - step_ext;
        end
    end

endmodule

// File: rtl/btc_ctrl_fsm.sv
module btc_ctrl_fsm
    import btc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_set,
    input  logic        cnt_wr,
    input  logic        fault,
    input  logic        xfer_ok,
    input  logic        bus_err,
    input  logic        at_last,
    input  logic        ext_mode,
    input  logic        clr_done,
    input  logic        clr_conf,
    output btc_state_e  state,
    output logic        load_en,
    output logic        dec_en,
    output logic        latch_en,
    output logic        done,
    output logic        conf,
    output logic        done_pulse
);

    btc_state_e state_nx;
    logic       good_xfer;
    logic       set_done;
    logic       set_conf;

    assign good_xfer = xfer_ok & ~bus_err;
    assign set_done  = (state == ST_RUN) & good_xfer & at_last;
    assign set_conf  = (state == ST_CHECK) & fault;
    assign load_en   = (state == ST_IDLE) & cnt_wr;
    assign latch_en  = (state == ST_IDLE) & start_set;
    assign dec_en    = (state == ST_RUN) & good_xfer;

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_set) state_nx = ST_CHECK;
            ST_CHECK: state_nx = fault ? ST_IDLE : ST_RUN;
            ST_RUN: begin
                if (bus_err)       state_nx = ST_IDLE;
                else if (set_done) state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // status outputs; a set beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            conf       <= 1'b0;
            done_pulse <= 1'b0;
        end else begin
            if (set_done)      done <= 1'b1;
            else if (clr_done) done <= 1'b0;
            if (set_conf)      conf <= 1'b1;
            else if (clr_conf) conf <= 1'b0;
            done_pulse <= set_done & ext_mode;
        end
    end

endmodule

// File: rtl/dma_byte_counter.sv
module dma_byte_counter
    import btc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [1:0]       size_code,
    input  logic             start_set,
    input  logic             ext_mode,
    input  logic             xfer_ok,
    input  logic             bus_err,
    input  logic             clr_done,
    input  logic             clr_conf,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             conf,
    output logic             busy,
    output logic             done_pulse
);

    btc_state_e         state_q;
    opsize_e            size_q;
    logic [STEP_W-1:0]  step;
    logic               fault;
    logic               at_last;
    logic               load_en;
    logic               dec_en;
    logic               latch_en;

    // operand size is captured with the start request and held for the run
    always_ff @(posedge clk) begin
        if (!rst_n)        size_q <= SZ_BYTE;
        else if (latch_en) size_q <= opsize_e'(size_code);
    end

    btc_size_check #(.CNT_W(CNT_W)) u_check (
        .size  (size_q),
        .count (count),
        .step  (step),
        .fault (fault)
    );

    btc_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (cnt_wdata),
        .dec_en   (dec_en),
        .step     (step),
        .count    (count),
        .at_last  (at_last)
    );

    btc_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_set  (start_set),
        .cnt_wr     (cnt_wr),
        .fault      (fault),
        .xfer_ok    (xfer_ok),
        .bus_err    (bus_err),
        .at_last    (at_last),
        .ext_mode   (ext_mode),
        .clr_done   (clr_done),
        .clr_conf   (clr_conf),
        .state      (state_q),
        .load_en    (load_en),
        .dec_en     (dec_en),
        .latch_en   (latch_en),
        .done       (done),
        .conf       (conf),
        .done_pulse (done_pulse)
    );

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/dma_byte_counter_chk.sv
module dma_byte_counter_chk
    import btc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             start_set,
    input logic             ext_mode,
    input logic             xfer_ok,
    input logic             bus_err,
    input logic [CNT_W-1:0] count,
    input logic             done,
    input logic             conf,
    input logic             busy,
    input logic             done_pulse,
    input btc_state_e       state_q,
    input opsize_e          size_q
);

    logic [CNT_W-1:0] exp_step;
    assign exp_step = (size_q == SZ_LONG) ? 4 : (size_q == SZ_WORD) ? 2 : 1;

    // R1
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && xfer_ok && !bus_err) |=> (count == $past(count) - $past(exp_step)));

    // R2
    p_done_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (count == '0 && !busy));

    // R3
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R3
    p_pulse_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> ($past(ext_mode) && done));

    // R8
    p_err_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && bus_err) |=> ($stable(count) && !busy));

    // R9
    p_write_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cnt_wr) |=> (count == $past(cnt_wdata)));

    // R6
    p_zero_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && count == '0) |=> (conf && !busy));

    // R12
    p_start_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_set) |=> busy);

endmodule

bind dma_byte_counter dma_byte_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_wr     (cnt_wr),
    .cnt_wdata  (cnt_wdata),
    .start_set  (start_set),
    .ext_mode   (ext_mode),
    .xfer_ok    (xfer_ok),
    .bus_err    (bus_err),
    .count      (count),
    .done       (done),
    .conf       (conf),
    .busy       (busy),
    .done_pulse (done_pulse),
    .state_q    (state_q),
    .size_q     (size_q)
);

// File: tb/sim_dma_byte_counter.sv
`timescale 1ns/1ps
module sim_dma_byte_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_wr = 0, start_set = 0, ext_mode = 0;
    logic        xfer_ok = 0, bus_err = 0, clr_done = 0, clr_conf = 0;
    logic [31:0] cnt_wdata = '0;
    logic [1:0]  size_code = 2'b00;
    logic [31:0] count;
    logic        done, conf, busy, done_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dma_byte_counter u0 (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .size_code(size_code), .start_set(start_set), .ext_mode(ext_mode),
        .xfer_ok(xfer_ok), .bus_err(bus_err), .clr_done(clr_done),
        .clr_conf(clr_conf), .count(count), .done(done), .conf(conf),
        .busy(busy), .done_pulse(done_pulse)
    );

    // ---------------- behavioural reference ----------------
    int          m_phase;   // 0 stopped, 1 validating, 2 counting
    int          m_size;
    longint      m_count;
    bit          m_done, m_conf, m_pulse;

    function automatic int bytes_of(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_size = 0; m_count = 0;
            m_done = 0; m_conf = 0; m_pulse = 0;
        end else begin
            if (clr_done) m_done = 0;
            if (clr_conf) m_conf = 0;
            m_pulse = 0;
            if (m_phase == 0) begin
                if (cnt_wr) m_count = cnt_wdata;
                if (start_set) begin m_phase = 1; m_size = int'(size_code); end
            end else if (m_phase == 1) begin
                if (m_count == 0 || bytes_of(m_size) == 0 ||
                    (m_count % bytes_of(m_size)) != 0) begin
                    m_conf = 1; m_phase = 0;
                end else m_phase = 2;
            end else begin
                if (bus_err) m_phase = 0;
                else if (xfer_ok) begin
                    m_count = m_count - bytes_of(m_size);
                    if (m_count == 0) begin
                        m_done = 1; m_pulse = ext_mode; m_phase = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R1 count vs model", count, m_count);
            check("R2 done vs model", done, m_done);
            check("R3 done_pulse vs model", done_pulse, m_pulse);
            check("R4 conf vs model", conf, m_conf);
            check("R12 busy vs model", busy, m_phase != 0);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load(input logic [31:0] v);
        cnt_wr = 1; cnt_wdata = v; tick(); cnt_wr = 0;
    endtask

    // start request; returns at the negedge after validation
    task automatic go(input logic [1:0] sz, input logic ext);
        size_code = sz; ext_mode = ext; start_set = 1; tick(); start_set = 0;
        check("R12 busy after start", busy, 1);
        tick();
    endtask

    task automatic xfers(input int n);
        xfer_ok = 1;
        for (int i = 0; i < n; i++) tick();
        xfer_ok = 0;
    endtask

    task automatic clear_flags();
        clr_done = 1; clr_conf = 1; tick(); clr_done = 0; clr_conf = 0;
    endtask

    initial begin
        repeat (4) tick();
        // R11 reset state
        check("R11 count", count, 0);
        check("R11 flags", {done, conf, busy, done_pulse}, 0);
        rst_n = 1;
        tick();

        // R1/R2/R3: 16 bytes, external mode
        load(32'd16); go(2'b00, 1'b1);
        check("R12 running after check", busy, 1);
        xfers(1);
        check("R1 byte step", count, 15);
        xfers(15);
        check("R2 done at zero", done, 1);
        check("R2 busy cleared", busy, 0);
        check("R3 pulse ext", done_pulse, 1);
        tick();
        check("R3 pulse one cycle", done_pulse, 0);
        check("R10 done sticky", done, 1);
        clear_flags();
        check("R10 done cleared", done, 0);

        // word, internal mode: no pulse
        load(32'd10); go(2'b01, 1'b0);
        xfers(1);
        check("R1 word step", count, 8);
        xfers(4);
        check("R2 word done", done, 1);
        check("R3 no pulse internal", done_pulse, 0);
        clear_flags();

        // long words
        load(32'd12); go(2'b10, 1'b1);
        xfers(1);
        check("R1 long step", count, 8);
        xfers(2);
        check("R2 long done", done, 1);
        clear_flags();

        // R4 odd count with words
        load(32'd7); go(2'b01, 1'b0);
        check("R4 conf set", conf, 1);
        check("R4 busy cleared", busy, 0);
        xfers(2);
        check("R4 count untouched", count, 7);
        clear_flags();
        check("R10 conf cleared", conf, 0);

        // R5 long with count 6
        load(32'd6); go(2'b10, 1'b0);
        check("R5 conf set", conf, 1);
        check("R5 count untouched", count, 6);
        clear_flags();

        // R6 zero count start
        load(32'd0); go(2'b00, 1'b0);
        check("R6 conf set", conf, 1);
        check("R6 busy cleared", busy, 0);
        clear_flags();

        // R7 reserved size; R10 set beats clear in the check cycle
        load(32'd8);
        size_code = 2'b11; start_set = 1; tick(); start_set = 0;
        clr_conf = 1; tick(); clr_conf = 0;
        check("R7 conf on reserved size", conf, 1);
        check("R10 set wins over clear", conf, 1);
        clear_flags();

        // R8 bus error mid run, with xfer_ok in the same cycle
        load(32'd20); go(2'b10, 1'b0);
        xfers(1);
        xfer_ok = 1; bus_err = 1; tick(); xfer_ok = 0; bus_err = 0;
        check("R8 count frozen", count, 16);
        check("R8 stopped", busy, 0);
        check("R8 no done", done, 0);

        // R9 write while busy ignored, then idle write accepted
        load(32'd8); go(2'b00, 1'b0);
        load(32'd100);
        check("R9 write ignored while busy", count, 8);
        bus_err = 1; tick(); bus_err = 0;
        load(32'd3);
        check("R9 write accepted when idle", count, 3);

        // xfer_ok in idle has no effect
        xfers(3);
        check("R1 no decrement when stopped", count, 3);

        repeat (3) tick();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL R12 watchdog expired after %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule